// File: doc/BRIEF.md
# Destination-Qualified Round-Robin FIFO Arbiter

This block is one output-port stage of a mesh router. Each of its client inputs feeds a private FIFO, so a request offered while the FIFO has room is always stored and never dropped. A round-robin arbiter then chooses one FIFO head per cycle and presents it on a single winner output with a valid flag. The winning head leaves its FIFO at the next rising clock edge.

Every request carries a precomputed next-hop direction in a three-bit field. The neighbouring tile supplies a separate ready signal for each of its five directions. A head may only compete when the ready for its own direction is high. A head stalled toward a busy direction therefore does not hold back heads in other FIFOs that point to free directions. The winner output is combinational from the registered FIFO state, and the downstream side takes the word in any cycle where the valid flag is high.

Top module: `dqrr_arb`

## Requirements
- R1: A synchronous active-high reset empties every FIFO and parks the round-robin pointer on client 0. In the cycle after reset, `winner_req_valid` is low and every bit of `push_ready` is high.
- R2: A client's word is stored when `push_valid` and `push_ready` are both high at a rising edge. `push_ready` is low when that FIFO holds `FIFO_DEPTH` words and is not being popped, and a word offered then is discarded.
- R3: Words from one client leave in the order in which they were stored.
- R4: The next-hop field is bits [HOP_LSB+2:HOP_LSB] of the request, coded North=0, East=1, South=2, West=3, Local=4, and `dn_ready` bit k is the ready for code k. A non-empty head competes only when `dn_ready` at its code is high, and codes 5 to 7 never compete.
- R5: `winner_req_valid` is high exactly when at least one head competes. `winner_req` then equals the granted head, and that head is removed at the next rising edge.
- R6: The search for a winner starts at the pointer and moves upward with wrap-around. After a grant, the pointer moves to the client after the winner, wrapping from NUM_CLIENTS-1 to 0.
- R7: In a cycle with no grant, the pointer keeps its value.
- R8: A full FIFO whose head is being granted raises `push_ready` in that cycle and accepts a new word at the same edge.
- R9: A head that cannot compete does not stop a head in another FIFO whose direction ready is high from winning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | NUM_CLIENTS | Per-client request strobe |
| push_req | input | NUM_CLIENTS*REQ_W | Client requests, client c in bits [c*REQ_W +: REQ_W] |
| push_ready | output | NUM_CLIENTS | Per-client FIFO can take a word |
| dn_ready | input | 5 | Downstream ready per next-hop code (bit k for code k) |
| winner_req | output | REQ_W | Granted head word |
| winner_req_valid | output | 1 | A head is granted this cycle |

## Verification
The assertions assume that `dn_ready`, `push_valid` and `push_req` carry known values at every rising edge after reset. They also assume that the downstream side takes the winner in any cycle where it is shown, so a grant is always counted as a pop. The stimulus changes inputs only on falling edges and samples half a period before the next rising edge. It only lowers or raises a direction ready between grants, which keeps it within that contract. Each scenario starts from a fresh reset, so the bench's own pointer model begins at client 0 every time.

// File: rtl/dqrr_pkg.sv
package dqrr_pkg;

    localparam int HOP_W     = 3;
    localparam int HOP_COUNT = 5;

    typedef enum logic [HOP_W-1:0] {
        HOP_NORTH = 3'd0,
        HOP_EAST  = 3'd1,
        HOP_SOUTH = 3'd2,
        HOP_WEST  = 3'd3,
        HOP_LOCAL = 3'd4
    } hop_e;

endpackage

// File: rtl/dqrr_fifo.sv
module dqrr_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_en,
    input  logic [W-1:0]  push_data,
    input  logic          pop_en,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] level
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push_en) begin
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop_en) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({push_en, pop_en})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_en) begin
            mem_q[st_q.wr] <= push_data;
        end
    end

    assign head  = mem_q[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign level = st_q.cnt;

endmodule

// File: rtl/dqrr_qualify.sv
module dqrr_qualify
    import dqrr_pkg::*;
#(
    parameter int N       = 4,
    parameter int W       = 32,
    parameter int HOP_LSB = 0
) (
    input  logic [N*W-1:0]       head_flat,
    input  logic [N-1:0]         empty,
    input  logic [HOP_COUNT-1:0] dn_ready,
    output logic [N-1:0]         elig
);

    localparam int PAD_W = 1 << HOP_W;

    logic [PAD_W-1:0] rdy_pad;
    assign rdy_pad = PAD_W'(dn_ready);

    for (genvar g = 0; g < N; g++) begin : g_cand
        logic [HOP_W-1:0] hop;
        assign hop     = head_flat[g*W + HOP_LSB +: HOP_W];
        assign elig[g] = !empty[g] && rdy_pad[hop];
    end

endmodule

// File: rtl/dqrr_rr_pick.sv
module dqrr_rr_pick #(
    parameter int N   = 4,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  elig,
    output logic          grant_valid,
    output logic [PW-1:0] grant_idx,
    output logic [PW-1:0] ptr
);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } rr_st_t;

    rr_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        grant_valid = 1'b0;
        grant_idx   = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = int'(st_q.ptr) + k;
            if (c >= N) begin
                c = c - N;
            end
            if (!grant_valid && elig[c]) begin
                grant_valid = 1'b1;
                grant_idx   = PW'(c);
            end
        end
        if (grant_valid) begin
            st_d.ptr = (grant_idx == PW'(N - 1)) ? '0 : grant_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;

endmodule

// File: rtl/dqrr_arb.sv
module dqrr_arb
    import dqrr_pkg::*;
#(
    parameter int NUM_CLIENTS = 4,
    parameter int FIFO_DEPTH  = 4,
    parameter int REQ_W       = 32,
    parameter int HOP_LSB     = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_CLIENTS-1:0]       push_valid,
    input  logic [NUM_CLIENTS*REQ_W-1:0] push_req,
    output logic [NUM_CLIENTS-1:0]       push_ready,
    input  logic [HOP_COUNT-1:0]         dn_ready,
    output logic [REQ_W-1:0]             winner_req,
    output logic                         winner_req_valid
);

    localparam int PTR_W = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1;
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic [NUM_CLIENTS*REQ_W-1:0] head_flat;
    logic [NUM_CLIENTS*LVL_W-1:0] fifo_lvl;
    logic [NUM_CLIENTS-1:0]       empty, full, elig, pop, push_en;
    logic [PTR_W-1:0]             grant_idx, rr_ptr;
    logic                         grant_valid;

    for (genvar g = 0; g < NUM_CLIENTS; g++) begin : g_client
        assign pop[g]        = grant_valid && (grant_idx == PTR_W'(g));
        assign push_ready[g] = !full[g] || pop[g];
        assign push_en[g]    = push_valid[g] && push_ready[g];

        dqrr_fifo #(
            .DEPTH (FIFO_DEPTH),
            .W     (REQ_W)
        ) fifo_i (
            .clk       (clk),
            .rst       (rst),
            .push_en   (push_en[g]),
            .push_data (push_req[g*REQ_W +: REQ_W]),
            .pop_en    (pop[g]),
            .head      (head_flat[g*REQ_W +: REQ_W]),
            .empty     (empty[g]),
            .full      (full[g]),
            .level     (fifo_lvl[g*LVL_W +: LVL_W])
        );
    end

    dqrr_qualify #(
        .N       (NUM_CLIENTS),
        .W       (REQ_W),
        .HOP_LSB (HOP_LSB)
    ) qual_i (
        .head_flat (head_flat),
        .empty     (empty),
        .dn_ready  (dn_ready),
        .elig      (elig)
    );

    dqrr_rr_pick #(
        .N (NUM_CLIENTS)
    ) pick_i (
        .clk         (clk),
        .rst         (rst),
        .elig        (elig),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .ptr         (rr_ptr)
    );

    assign winner_req_valid = grant_valid;
    assign winner_req       = head_flat[int'(grant_idx)*REQ_W +: REQ_W];

endmodule

// File: rtl/dqrr_arb_chk.sv
module dqrr_arb_chk #(
    parameter int N       = 4,
    parameter int DEPTH   = 4,
    parameter int W       = 32,
    parameter int HOP_LSB = 0,
    parameter int PW      = 2,
    parameter int LW      = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           winner_req_valid,
    input logic [W-1:0]   winner_req,
    input logic [4:0]     dn_ready,
    input logic [PW-1:0]  rr_ptr,
    input logic [PW-1:0]  grant_idx,
    input logic [N*LW-1:0] fifo_lvl
);

    logic [7:0]    rdy_pad;
    logic [2:0]    win_hop;
    logic [PW-1:0] nxt_ptr;

    assign rdy_pad = {3'b000, dn_ready};
    assign win_hop = winner_req[HOP_LSB +: 3];
    assign nxt_ptr = (grant_idx == PW'(N - 1)) ? '0 : grant_idx + 1'b1;

    // R1: nothing is offered in the first cycle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !winner_req_valid);

    // R4: a granted head always has its direction ready
    a_r4_hop_ready: assert property (@(posedge clk) disable iff (rst)
        winner_req_valid |-> rdy_pad[win_hop]);

    // R5: a grant always comes from a FIFO holding a word
    a_r5_grant_nonempty: assert property (@(posedge clk) disable iff (rst)
        winner_req_valid |-> (fifo_lvl[int'(grant_idx)*LW +: LW] != '0));

    // R6: the pointer steps past the winner
    a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
        winner_req_valid |=> (rr_ptr == $past(nxt_ptr)));

    // R7: the pointer holds when nothing wins
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !winner_req_valid |=> $stable(rr_ptr));

    for (genvar g = 0; g < N; g++) begin : g_lvl
        // R2: no FIFO ever holds more than its depth
        a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
            fifo_lvl[g*LW +: LW] <= LW'(DEPTH));
    end

endmodule

bind dqrr_arb dqrr_arb_chk #(
    .N       (NUM_CLIENTS),
    .DEPTH   (FIFO_DEPTH),
    .W       (REQ_W),
    .HOP_LSB (HOP_LSB),
    .PW      (PTR_W),
    .LW      (LVL_W)
) chk_i (
    .clk              (clk),
    .rst              (rst),
    .winner_req_valid (winner_req_valid),
    .winner_req       (winner_req),
    .dn_ready         (dn_ready),
    .rr_ptr           (rr_ptr),
    .grant_idx        (grant_idx),
    .fifo_lvl         (fifo_lvl)
);

// File: tb/dqrr_arb_tb.sv
module dqrr_arb_tb_top;

    localparam int N = 4;
    localparam int D = 4;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   pv  = '0;
    logic [N*W-1:0] preq = '0;
    logic [N-1:0]   pr;
    logic [4:0]     dn  = '0;
    logic [W-1:0]   wreq;
    logic           wv;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dqrr_arb #(
        .NUM_CLIENTS (N),
        .FIFO_DEPTH  (D),
        .REQ_W       (W),
        .HOP_LSB     (0)
    ) dut_i (
        .clk              (clk),
        .rst              (rst),
        .push_valid       (pv),
        .push_req         (preq),
        .push_ready       (pr),
        .dn_ready         (dn),
        .winner_req       (wreq),
        .winner_req_valid (wv)
    );

    function automatic logic [W-1:0] mk(int c, int seq, int hop);
        return {8'(c), 16'(seq), 5'b0, 3'(hop)};
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pv = '0; dn = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic load(int c, logic [W-1:0] v);
        pv[c] = 1'b1;
        preq[c*W +: W] = v;
        step();
        pv[c] = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 valid low", W'(wv), W'(0));
        check("R1 ready high", W'(pr), W'(4'hF));
    endtask

    task automatic t_round_robin();
        do_reset();
        for (int s = 0; s < 2; s++) begin
            pv = '1;
            for (int c = 0; c < N; c++) preq[c*W +: W] = mk(c, s, 4);
            step();
            pv = '0;
        end
        #1;
        check("R4 all gated", W'(wv), W'(0));
        dn = 5'h1F;
        #1;
        for (int i = 0; i < 2 * N; i++) begin
            check("R5 valid", W'(wv), W'(1));
            check("R6 R3 order", wreq, mk(i % N, i / N, 4));
            step();
        end
        check("R5 drained", W'(wv), W'(0));
    endtask

    task automatic t_gate();
        do_reset();
        load(0, mk(0, 0, 1));
        load(1, mk(1, 0, 2));
        check("R4 blocked", W'(wv), W'(0));
        dn = 5'b00100;
        #1;
        check("R9 bypass", wreq, mk(1, 0, 2));
        check("R9 bypass valid", W'(wv), W'(1));
        step();
        check("R9 c0 still held", W'(wv), W'(0));
        dn = 5'b00010;
        #1;
        check("R4 east", wreq, mk(0, 0, 1));
        step();
        check("R5 empty", W'(wv), W'(0));
        load(2, mk(2, 0, 6));
        dn = 5'h1F;
        #1;
        check("R4 code 6", W'(wv), W'(0));
    endtask

    task automatic t_hold();
        do_reset();
        load(0, mk(0, 0, 4));
        load(1, mk(1, 0, 4));
        load(2, mk(2, 0, 4));
        dn = 5'h1F;
        #1;
        check("R6 first", wreq, mk(0, 0, 4));
        step();
        dn = '0;
        #1;
        check("R7 idle", W'(wv), W'(0));
        repeat (3) step();
        load(0, mk(0, 1, 4));
        dn = 5'h1F;
        #1;
        check("R7 ptr held", wreq, mk(1, 0, 4));
        step();
        check("R6 next", wreq, mk(2, 0, 4));
        step();
        check("R6 wrap", wreq, mk(0, 1, 4));
        step();
        check("R5 done", W'(wv), W'(0));
    endtask

    task automatic t_full();
        do_reset();
        for (int k = 0; k < D; k++) load(0, mk(0, k, 0));
        check("R2 full ready", W'(pr[0]), W'(0));
        check("R2 others ready", W'(pr[3:1]), W'(3'b111));
        pv[0] = 1'b1;
        preq[0 +: W] = mk(0, 99, 0);
        step();
        pv[0] = 1'b0;
        #1;
        check("R2 still full", W'(pr[0]), W'(0));
        dn = 5'b00001;
        pv[0] = 1'b1;
        preq[0 +: W] = mk(0, 50, 0);
        #1;
        check("R8 ready on pop", W'(pr[0]), W'(1));
        check("R8 head", wreq, mk(0, 0, 0));
        step();
        pv[0] = 1'b0;
        #1;
        for (int k = 1; k < D; k++) begin
            check("R3 order", wreq, mk(0, k, 0));
            step();
        end
        check("R8 pushed word", wreq, mk(0, 50, 0));
        step();
        check("R2 dropped word", W'(wv), W'(0));
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        t_reset();
        t_round_robin();
        t_gate();
        t_hold();
        t_full();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule